// File: doc/BRIEF.md
# Frequency-Ranked Victim Selector with Aging Floor

This block chooses which way of one N-way cache set is replaced on a miss, ranking each way by how often it has been referenced. Each way holds a saturating reference count and a priority key. The key is the count plus a set-wide age floor, and it is recomputed whenever the line is filled or hit again. The victim is always the way with the smallest key.

When a valid line is evicted, the age floor rises to that line's key. A line that was very popular long ago therefore keeps its old key, while every newly filled or re-referenced line starts from the higher floor. As a result, the stale line eventually becomes the smallest key and is replaced.

The surrounding cache controller does the tag lookup. It reports every access with a hit flag and the way that hit. On a miss it reads the victim, which is combinational and valid in the same cycle, and pulses the fill strobe to install the new line there. The current age and all keys are brought out so they can be observed.

Top module: `lfuda_sel`

## Requirements
- R1: While reset is high, and in the first cycle after it, every way is invalid, every key is 0, the age is 0 and the victim index is 0.
- R2: While any way is invalid, the victim is the lowest-numbered invalid way. A fill into an invalid way sets that way's count to 1 and its key to age+1, and the age stays unchanged.
- R3: A hit (access strobe and hit flag both high) on a valid way increases that way's count by 1, stopping at 2^CNT_W-1. In the next cycle its key equals the new count plus the current age.
- R4: When all ways are valid, the victim is the way with the smallest key, and ties go to the lowest index. The victim is valid in the same cycle as the inputs, with no clock edge in between.
- R5: A fill into a valid victim sets the age to that victim's key. The new line gets count 1 and key = new age + 1.
- R6: The age never decreases, and it is never larger than the key of any valid way.
- R7: Sums that exceed 2^KEY_W-1 are held at 2^KEY_W-1 and never wrap.
- R8: A hit naming an invalid way changes nothing. A fill in the same cycle as a hit is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_vld | input | 1 | Access strobe |
| acc_hit | input | 1 | Access hit the set (valid with acc_vld) |
| hit_way | input | $clog2(WAYS) | Way index of the hit |
| fill_vld | input | 1 | Install a new line in the current victim way |
| victim_way | output | $clog2(WAYS) | Way chosen for replacement |
| age_o | output | KEY_W | Current age floor |
| keys_o | output | WAYS*KEY_W | Keys of all ways, way i at bits [i*KEY_W +: KEY_W] |

## Verification
The hardest states to reach from the ports are a full set in which keys tie or sit at the saturation ceiling while the age floor is also close to it. Reaching them takes many evictions, each of which raises the floor, interleaved with enough hits to push counts to their limit. The bench therefore uses a narrow count and key width and runs several long, hit-heavy pseudo-random bursts, with a reset between bursts. In every cycle it compares the victim, the age and all keys against an arithmetic model. It also confirms that the saturated value was actually reached.

// File: rtl/lfuda_pkg.sv
package lfuda_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_HIT  = 2'd1,
        OP_FILL = 2'd2
    } way_op_e;

    // Clamp a non-negative sum to a ceiling.
    function automatic int unsigned clamp_to(input int unsigned val, input int unsigned ceil);
        return (val > ceil) ? ceil : val;
    endfunction

endpackage

// File: rtl/lfuda_min_tree.sv
module lfuda_min_tree #(
    parameter int WAYS  = 8,
    parameter int KEY_W = 8,
    localparam int IDX_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]       valid,
    input  logic [WAYS*KEY_W-1:0] keys,
    output logic [IDX_W-1:0]      win
);
    localparam int NODES = 2 * WAYS - 1;
    localparam int RW    = KEY_W + 1;

    // Rank = {valid, key}: invalid ways rank below every valid way.
    logic [RW-1:0]    node_rank [NODES];
    logic [IDX_W-1:0] node_idx  [NODES];

    for (genvar i = 0; i < WAYS; i++) begin : g_leaf
        assign node_rank[WAYS-1+i] = {valid[i], keys[i*KEY_W +: KEY_W]};
        assign node_idx[WAYS-1+i]  = IDX_W'(i);
    end

    // Heap layout: left child always covers lower way numbers, so ties keep left.
    for (genvar n = 0; n < WAYS - 1; n++) begin : g_node
        logic take_right;
        assign take_right   = node_rank[2*n+2] < node_rank[2*n+1];
        assign node_rank[n] = take_right ? node_rank[2*n+2] : node_rank[2*n+1];
        assign node_idx[n]  = take_right ? node_idx[2*n+2]  : node_idx[2*n+1];
    end

    assign win = node_idx[0];

endmodule

// File: rtl/lfuda_way.sv
module lfuda_way
    import lfuda_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int KEY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  way_op_e          op,
    input  logic [KEY_W-1:0] age_cur,
    input  logic [KEY_W-1:0] age_next,
    output logic             valid_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [KEY_W-1:0] key_o
);
    localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;
    localparam int unsigned KEY_MAX = (1 << KEY_W) - 1;

    typedef struct packed {
        logic             valid;
        logic [CNT_W-1:0] cnt;
        logic [KEY_W-1:0] key;
    } line_t;

    line_t line_q, line_d;
    int unsigned cnt_up;

    always_comb begin
        line_d = line_q;
        cnt_up = clamp_to(int'(line_q.cnt) + 1, CNT_MAX);
        case (op)
            OP_HIT: if (line_q.valid) begin
                line_d.cnt = CNT_W'(cnt_up);
                line_d.key = KEY_W'(clamp_to(cnt_up + int'(age_cur), KEY_MAX));
            end
            OP_FILL: begin
                line_d.valid = 1'b1;
                line_d.cnt   = CNT_W'(1);
                line_d.key   = KEY_W'(clamp_to(int'(age_next) + 1, KEY_MAX));
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) line_q <= '0;
        else     line_q <= line_d;
    end

    assign valid_o = line_q.valid;
    assign cnt_o   = line_q.cnt;
    assign key_o   = line_q.key;

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_HIT && line_q.valid && int'(line_q.cnt) < CNT_MAX)
        |=> int'(line_q.cnt) == int'($past(line_q.cnt)) + 1);

    // R2
    fill_init_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_FILL) |=> (line_q.valid && line_q.cnt == CNT_W'(1)));

endmodule

// File: rtl/lfuda_sel.sv
module lfuda_sel
    import lfuda_pkg::*;
#(
    parameter int WAYS  = 8,
    parameter int CNT_W = 4,
    parameter int KEY_W = 8,
    localparam int IDX_W = $clog2(WAYS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  acc_vld,
    input  logic                  acc_hit,
    input  logic [IDX_W-1:0]      hit_way,
    input  logic                  fill_vld,
    output logic [IDX_W-1:0]      victim_way,
    output logic [KEY_W-1:0]      age_o,
    output logic [WAYS*KEY_W-1:0] keys_o
);
    logic [KEY_W-1:0] age_q, age_d;
    logic [WAYS-1:0]  way_valid;
    logic [CNT_W-1:0] way_cnt [WAYS];
    logic [KEY_W-1:0] way_key [WAYS];
    logic             hit_now, fill_now;

    assign hit_now  = acc_vld & acc_hit;
    assign fill_now = fill_vld & ~hit_now;

    for (genvar i = 0; i < WAYS; i++) begin : g_way
        way_op_e op_i;
        assign op_i = (hit_now && hit_way == IDX_W'(i))     ? OP_HIT  :
                      (fill_now && victim_way == IDX_W'(i)) ? OP_FILL : OP_IDLE;

        lfuda_way #(.CNT_W(CNT_W), .KEY_W(KEY_W)) way_i (
            .clk      (clk),
            .rst      (rst),
            .op       (op_i),
            .age_cur  (age_q),
            .age_next (age_d),
            .valid_o  (way_valid[i]),
            .cnt_o    (way_cnt[i]),
            .key_o    (way_key[i])
        );
        assign keys_o[i*KEY_W +: KEY_W] = way_key[i];
    end

    lfuda_min_tree #(.WAYS(WAYS), .KEY_W(KEY_W)) tree_i (
        .valid (way_valid),
        .keys  (keys_o),
        .win   (victim_way)
    );

    // Eviction of a valid line lifts the floor to the evicted key.
    assign age_d = (fill_now && way_valid[victim_way]) ? way_key[victim_way] : age_q;

    always_ff @(posedge clk) begin
        if (rst) age_q <= '0;
        else     age_q <= age_d;
    end

    assign age_o = age_q;

    // R6
    age_mono_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> age_q >= $past(age_q));

    // R5
    age_evict_chk: assert property (@(posedge clk) disable iff (rst)
        (fill_now && way_valid[victim_way]) |=> age_q == $past(way_key[victim_way]));

    // R2
    invalid_first_chk: assert property (@(posedge clk) disable iff (rst)
        (way_valid != '1) |-> !way_valid[victim_way]);

    for (genvar i = 0; i < WAYS; i++) begin : g_chk
        // R6
        age_floor_chk: assert property (@(posedge clk) disable iff (rst)
            way_valid[i] |-> age_q <= way_key[i]);

        // R4
        victim_min_chk: assert property (@(posedge clk) disable iff (rst)
            (way_valid == '1) |-> (way_key[victim_way] < way_key[i] ||
             (way_key[victim_way] == way_key[i] && victim_way <= IDX_W'(i))));
    end

endmodule

// File: tb/lfuda_sel_tb.sv
module lfuda_sel_tb_top;
    localparam int WAYS = 4, CNT_W = 3, KEY_W = 5, IW = 2;
    localparam int CMAX = 7, KMAX = 31;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic acc_vld = 1'b0, acc_hit = 1'b0, fill_vld = 1'b0;
    logic [IW-1:0] hit_way = '0;
    logic [IW-1:0] victim_way;
    logic [KEY_W-1:0] age_o;
    logic [WAYS*KEY_W-1:0] keys_o;

    always #10 clk = ~clk;

    lfuda_sel #(.WAYS(WAYS), .CNT_W(CNT_W), .KEY_W(KEY_W)) dut_i (
        .clk(clk), .rst(rst), .acc_vld(acc_vld), .acc_hit(acc_hit),
        .hit_way(hit_way), .fill_vld(fill_vld), .victim_way(victim_way),
        .age_o(age_o), .keys_o(keys_o)
    );

    int total = 0, bad = 0, sat_seen = 0;
    int m_val [WAYS], m_cnt [WAYS], m_key [WAYS], m_age;
    logic [15:0] lfsr = 16'hACE1;

    function automatic int mn(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    function automatic int exp_victim();
        int b = 0;
        for (int i = 1; i < WAYS; i++)
            if (m_val[i] * 64 + m_key[i] < m_val[b] * 64 + m_key[b]) b = i;
        return b;
    endfunction

    function automatic int key_of(input int w);
        return int'(keys_o[w*KEY_W +: KEY_W]);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; acc_vld = 0; acc_hit = 0; fill_vld = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < WAYS; i++) begin m_val[i] = 0; m_cnt[i] = 0; m_key[i] = 0; end
        m_age = 0;
        #1;
        chk("R1 victim", int'(victim_way), 0);
        chk("R1 age", int'(age_o), 0);
        for (int i = 0; i < WAYS; i++) chk("R1 key", key_of(i), 0);
    endtask

    task automatic step(input bit h, input int hw, input bit f, input bit miss);
        int ev;
        @(negedge clk);
        acc_vld = h | miss; acc_hit = h; hit_way = IW'(hw); fill_vld = f;
        #1;
        ev = exp_victim();
        chk(m_val[ev] != 0 ? "R4 victim" : "R2 victim", int'(victim_way), ev);
        @(posedge clk);
        if (h) begin
            if (m_val[hw] != 0) begin
                m_cnt[hw] = mn(m_cnt[hw] + 1, CMAX);
                m_key[hw] = mn(m_cnt[hw] + m_age, KMAX);
            end
        end else if (f) begin
            if (m_val[ev] != 0) m_age = m_key[ev];
            m_val[ev] = 1; m_cnt[ev] = 1;
            m_key[ev] = mn(1 + m_age, KMAX);
        end
        #2;
        chk("R5 age", int'(age_o), m_age);
        for (int i = 0; i < WAYS; i++) begin
            if (m_key[i] == KMAX) begin
                sat_seen++;
                chk("R7 key", key_of(i), m_key[i]);
            end else begin
                chk("R3 key", key_of(i), m_key[i]);
            end
            if (m_val[i] != 0) chk("R6 floor", int'(age_o) <= key_of(i), 1);
        end
        acc_vld = 0; acc_hit = 0; fill_vld = 0;
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int pre_v, pre_k, pre_age;
        do_reset();
        // R8: hit on an invalid way leaves everything at zero
        step(1, 2, 0, 0);
        chk("R8 invalid hit key", key_of(2), 0);
        chk("R8 invalid hit victim", int'(victim_way), 0);
        // R2: fills land in ways 0..3 in order
        for (int i = 0; i < WAYS; i++) step(0, 0, 1, 1);
        step(1, 0, 0, 0); step(1, 0, 0, 0); step(1, 1, 0, 0);
        // R8: hit and fill together, fill dropped
        @(negedge clk); #1;
        pre_v = int'(victim_way); pre_k = key_of(pre_v); pre_age = int'(age_o);
        step(1, 3, 1, 0);
        chk("R8 fill dropped key", key_of(pre_v), pre_k);
        chk("R8 fill dropped age", int'(age_o), pre_age);
        // R5: eviction lifts the floor
        step(0, 0, 1, 1);
        step(0, 0, 1, 1);
        // pseudo-random hit-heavy bursts
        for (int b = 0; b < 5; b++) begin
            do_reset();
            for (int s = 0; s < 600; s++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                case (lfsr[2:0])
                    3'd0, 3'd1: step(0, 0, 1, 1);
                    3'd2:       step(1, int'(lfsr[4:3]), 1, 0);
                    3'd3:       step(0, 0, 0, 0);
                    default:    step(1, int'(lfsr[4:3]), 0, 0);
                endcase
            end
        end
        chk("R7 saturation reached", sat_seen > 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule